// File: doc/BRIEF.md
# Delta-Sigma ADC Setup and Streaming Sequencer

This controller takes a delta-sigma converter with a serial port from power-up to a steady flow of samples. It watches the converter's active-low data-ready line. It sends a fixed series of commands and register writes, and it starts the transactions that need it on a falling edge of that line. Fixed settling gaps, counted in microseconds, separate the transactions. The last command switches the converter to continuous read mode. From then on the block clocks out one 24-bit sample for each data-ready falling edge.

The block contains a one-byte serial shifter and a microsecond tick counter. The shifter keeps the serial clock low when idle, changes its output on the rising edge and samples its input on the falling edge. Each sample appears for one cycle with a valid strobe. A second output carries the same sample sign-extended to 32 bits. A timeout flag reports a data-ready line that stays high too long while the sequencer waits on it.

Top module: `adc_stream_seq`

## Requirements
- R1: While reset is held, `sclk`, `mosi`, `sample_valid`, `timeout` and `sample_data` are all zero.
- R2: The serial clock idles low and has a period of 2*SCLK_HALF cycles within a byte. `mosi` changes only on a rising `sclk` edge. Bytes go out MSB first, and `miso` is sampled on the falling edge.
- R3: The first transaction is the single stop-continuous byte 0x0F, started by a data-ready falling edge.
- R4: On the next falling edge three register writes follow back to back. Each write is an opcode byte 0x50 OR'd with the address, a count byte 0x00 and a value byte: status (0x50,0x00,0x00), AD control (0x52,0x00,0x00) and data rate (0x53,0x00,0xC0). Each write is followed by an idle gap of at least 5*CLK_PER_US cycles. Only the first of the three waits for data-ready.
- R5: The self-calibration byte 0xF0 is sent on the next data-ready falling edge, followed by a gap of at least 5*CLK_PER_US cycles.
- R6: The input-mux write 0x51,0x00,0x01 is sent on the next data-ready falling edge.
- R7: The start-continuous byte 0x03 is sent on the next data-ready falling edge. After a gap of 8*CLK_PER_US to 8*CLK_PER_US+2*SCLK_HALF+8 cycles, a 24-bit read is clocked with `mosi` bytes of 0x00.
- R8: Every transaction that waits on data-ready puts out its first rising `sclk` edge between 3 and 2*SCLK_HALF+8 cycles after the line goes low.
- R9: In the clock cycle that follows the edge carrying a read's 24th falling `sclk` edge, `sample_valid` is high for exactly one cycle. `sample_data` then holds the bits read, first bit as MSB, and changes at no other time.
- R10: `sample_wide` equals `sample_data` sign-extended from bit 23 to 32 bits.
- R11: After the first read, each later data-ready falling edge starts another 24-bit read with 0x00 on `mosi`.
- R12: If data-ready does not fall within TIMEOUT_CYC cycles of entering a wait, `timeout` rises exactly TIMEOUT_CYC cycles after the wait began. It clears when a falling edge is seen, and the sequence then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial data to the converter |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_data | output | 24 | Last sample read |
| sample_wide | output | 32 | Last sample, sign-extended |
| timeout | output | 1 | Data-ready wait exceeded TIMEOUT_CYC cycles |

## Verification
A data-ready falling edge passes through two synchronizer stages and the state register. The first rising serial clock edge therefore comes 4+SCLK_HALF cycles after the line is driven low. The bench checks this inside a window tied to the most recent falling edge it drove. A gap is measured from the last falling serial clock edge of one transaction to the first rising edge of the next. The bench compares that span with the microsecond count times CLK_PER_US. The sample strobe is due on the cycle after the edge carrying the 24th falling serial clock edge. A behavioural slave model in the bench marks that edge and compares the strobe, the sample and the timeout flag on every clock. The timeout is due exactly TIMEOUT_CYC cycles after the strobe that opens the wait, and the bench samples it two cycles either side of that point.

// File: rtl/adcseq_pkg.sv
// Package: shared types and fixed register addresses of the setup sequencer.
// Assumes the converter decodes a write opcode as base OR register address.
package adcseq_pkg;
    localparam int GAP_W = 8;

    localparam logic [7:0] ADDR_STATUS = 8'h00;
    localparam logic [7:0] ADDR_MUX    = 8'h01;
    localparam logic [7:0] ADDR_ADCON  = 8'h02;
    localparam logic [7:0] ADDR_DRATE  = 8'h03;

    localparam logic [3:0] STEP_STREAM = 4'd8;

    typedef enum logic [1:0] {ST_WAIT, ST_XFER, ST_GAP} seq_state_t;

    typedef struct packed {
        logic             gated;
        logic [1:0]       nbytes;
        logic [7:0]       b0;
        logic [7:0]       b1;
        logic [7:0]       b2;
        logic [GAP_W-1:0] gap_us;
        logic             is_read;
    } step_t;
endpackage

// File: rtl/us_tick.sv
// Microsecond tick: pulses once every CLK_PER_US cycles while clr is low.
// Assumes clr is held high outside a gap so that each gap starts from zero.
module us_tick #(
    parameter int CLK_PER_US = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt;

    // Count system cycles within one microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/drdy_edge.sv
// Data-ready edge finder: synchronizes the asynchronous active-low line and
// flags one cycle per high-to-low transition. Assumes pulses span >= 2 cycles.
module drdy_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic fall
);
    logic s1, s2, s3;

    // Two-stage synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= drdy_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 && !s2;
endmodule

// File: rtl/spi_byte_shift.sv
// Byte shifter: sends and receives one byte MSB first. The serial clock idles
// low, output changes on its rising edge, input is taken on its falling edge.
// Assumes start is only raised while busy and done are both low.
module spi_byte_shift #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HW-1:0] H_LAST = HW'(SCLK_HALF - 1);

    logic [HW-1:0] phase;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh;

    // Half-period timing, bit shifting and the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            bitn    <= '0;
            tx_sh   <= '0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_sh <= tx_byte;
                    phase <= '0;
                    bitn  <= '0;
                end
            end else if (phase != H_LAST) begin
                phase <= phase + 1'b1;
            end else begin
                phase <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    mosi  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end else begin
                    sclk    <= 1'b0;
                    rx_byte <= {rx_byte[6:0], miso};
                    bitn    <= bitn + 1'b1;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_stream_seq.sv
// Setup and streaming sequencer: steps through the fixed configuration list,
// gating chosen steps on a data-ready falling edge and following chosen steps
// with a microsecond gap, then reads one sample per data-ready falling edge.
// Assumes SAMPLE_W is a whole number of bytes, at most three.
module adc_stream_seq
    import adcseq_pkg::*;
#(
    parameter int         CLK_PER_US  = 8,
    parameter int         SCLK_HALF   = 2,
    parameter int         TIMEOUT_CYC = 100000,
    parameter int         GAP_CFG_US  = 5,
    parameter int         GAP_RUN_US  = 8,
    parameter int         SAMPLE_W    = 24,
    parameter int         WIDE_W      = 32,
    parameter logic [7:0] OP_STOP     = 8'h0F,
    parameter logic [7:0] OP_START    = 8'h03,
    parameter logic [7:0] OP_CAL      = 8'hF0,
    parameter logic [7:0] OP_WREG     = 8'h50,
    parameter logic [7:0] VAL_STATUS  = 8'h00,
    parameter logic [7:0] VAL_ADCON   = 8'h00,
    parameter logic [7:0] VAL_DRATE   = 8'hC0,
    parameter logic [7:0] VAL_MUX     = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                drdy_n,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                sample_valid,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic [WIDE_W-1:0]   sample_wide,
    output logic                timeout
);
    localparam int RD_BYTES = SAMPLE_W / 8;
    localparam int TO_W     = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);
    localparam logic [TO_W-1:0] TO_MAX  = TO_W'(TIMEOUT_CYC);

    // Describes one step of the fixed sequence.
    function automatic step_t step_info(input logic [3:0] s);
        step_t r;
        r = '0;
        case (s)
            4'd0: begin r.gated = 1'b1; r.nbytes = 2'd1; r.b0 = OP_STOP; end
            4'd1: begin
                r.gated = 1'b1; r.nbytes = 2'd3; r.b0 = OP_WREG | ADDR_STATUS;
                r.b2 = VAL_STATUS; r.gap_us = GAP_W'(GAP_CFG_US);
            end
            4'd2: begin
                r.nbytes = 2'd3; r.b0 = OP_WREG | ADDR_ADCON;
                r.b2 = VAL_ADCON; r.gap_us = GAP_W'(GAP_CFG_US);
            end
            4'd3: begin
                r.nbytes = 2'd3; r.b0 = OP_WREG | ADDR_DRATE;
                r.b2 = VAL_DRATE; r.gap_us = GAP_W'(GAP_CFG_US);
            end
            4'd4: begin
                r.gated = 1'b1; r.nbytes = 2'd1; r.b0 = OP_CAL;
                r.gap_us = GAP_W'(GAP_CFG_US);
            end
            4'd5: begin
                r.gated = 1'b1; r.nbytes = 2'd3; r.b0 = OP_WREG | ADDR_MUX;
                r.b2 = VAL_MUX;
            end
            4'd6: begin
                r.gated = 1'b1; r.nbytes = 2'd1; r.b0 = OP_START;
                r.gap_us = GAP_W'(GAP_RUN_US);
            end
            4'd7:    begin r.nbytes = 2'(RD_BYTES); r.is_read = 1'b1; end
            default: begin r.gated = 1'b1; r.nbytes = 2'(RD_BYTES); r.is_read = 1'b1; end
        endcase
        return r;
    endfunction

    // Tells whether a step waits on data-ready.
    function automatic logic step_gated(input logic [3:0] s);
        return !(s == 4'd2 || s == 4'd3 || s == 4'd7);
    endfunction

    seq_state_t          state;
    logic [3:0]          step, nxt_step;
    logic [1:0]          bidx;
    logic [GAP_W-1:0]    us_cnt;
    logic [TO_W-1:0]     wait_cnt;
    logic [SAMPLE_W-1:0] acc;
    step_t               cur;
    logic [7:0]          tx_byte, rx_byte;
    logic                sh_start, sh_busy, sh_done, drdy_fall, tick, in_gap;

    drdy_edge u_edge (.clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .fall(drdy_fall));

    us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(!in_gap), .tick(tick)
    );

    spi_byte_shift #(.SCLK_HALF(SCLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(sh_busy),
        .done(sh_done), .rx_byte(rx_byte)
    );

    // Current step decode, byte selection and shifter launch.
    always_comb begin
        cur      = step_info(step);
        nxt_step = (step >= STEP_STREAM) ? STEP_STREAM : step + 4'd1;
        case (bidx)
            2'd0:    tx_byte = cur.b0;
            2'd1:    tx_byte = cur.b1;
            default: tx_byte = cur.b2;
        endcase
        sh_start = (state == ST_XFER) && !sh_busy && !sh_done;
    end

    assign in_gap      = (state == ST_GAP);
    assign sample_wide = {{(WIDE_W - SAMPLE_W){sample_data[SAMPLE_W-1]}}, sample_data};

    // Sequencer state, gap and wait counters, sample capture and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_WAIT;
            step         <= '0;
            bidx         <= '0;
            us_cnt       <= '0;
            wait_cnt     <= '0;
            acc          <= '0;
            sample_data  <= '0;
            sample_valid <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            case (state)
                ST_WAIT: begin
                    if (drdy_fall) begin
                        state    <= ST_XFER;
                        bidx     <= '0;
                        wait_cnt <= '0;
                        timeout  <= 1'b0;
                    end else if (wait_cnt != TO_MAX) begin
                        wait_cnt <= wait_cnt + 1'b1;
                        if (wait_cnt == TO_LAST) timeout <= 1'b1;
                    end
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (cur.is_read) acc <= {acc[SAMPLE_W-9:0], rx_byte};
                        if (bidx != cur.nbytes - 2'd1) begin
                            bidx <= bidx + 2'd1;
                        end else begin
                            if (cur.is_read) begin
                                sample_data  <= {acc[SAMPLE_W-9:0], rx_byte};
                                sample_valid <= 1'b1;
                            end
                            if (cur.gap_us != '0) begin
                                state  <= ST_GAP;
                                us_cnt <= '0;
                            end else begin
                                step     <= nxt_step;
                                bidx     <= '0;
                                wait_cnt <= '0;
                                state    <= step_gated(nxt_step) ? ST_WAIT : ST_XFER;
                            end
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (us_cnt == cur.gap_us - 1'b1) begin
                            step     <= nxt_step;
                            bidx     <= '0;
                            wait_cnt <= '0;
                            state    <= step_gated(nxt_step) ? ST_WAIT : ST_XFER;
                        end else begin
                            us_cnt <= us_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_stream_seq_chk.sv
// Checker: temporal properties of the sequencer, bound to its top module.
// Assumes the bound names exist inside adc_stream_seq.
module adc_stream_seq_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sclk,
    input logic                mosi,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] sample_data,
    input logic                timeout,
    input logic                sh_busy,
    input logic                drdy_fall,
    input logic                in_gap
);
    a_r2_mosi_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $rose(sclk));

    a_r2_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> !sclk);

    a_r4_no_shift_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> !sh_busy);

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_data) |-> sample_valid);

    a_r12_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout) |-> $past(drdy_fall));
endmodule

bind adc_stream_seq adc_stream_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .timeout(timeout), .sh_busy(sh_busy), .drdy_fall(drdy_fall),
    .in_gap(in_gap)
);

// File: tb/adc_stream_seq_tb.sv
// Bench: behavioural converter model driving data-ready and miso, decoding
// mosi, and comparing outputs every clock against expectations.
module adc_stream_seq_tb;
    localparam int CPU    = 10;
    localparam int HALF   = 2;
    localparam int TO     = 600;
    localparam int PERIOD = 400;
    localparam int HI     = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drdy_n = 1'b1;
    logic        miso = 1'b0;
    logic        sclk, mosi, sample_valid, timeout;
    logic [23:0] sample_data;
    logic [31:0] sample_wide;

    int n_chk = 0;
    int n_bad = 0;

    adc_stream_seq #(.CLK_PER_US(CPU), .SCLK_HALF(HALF), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .miso(miso), .sclk(sclk),
        .mosi(mosi), .sample_valid(sample_valid), .sample_data(sample_data),
        .sample_wide(sample_wide), .timeout(timeout)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        case (i)
            0: return 8'h0F;
            1: return 8'h50;  4: return 8'h52;  7: return 8'h53;
            9: return 8'hC0;  10: return 8'hF0; 11: return 8'h51;
            13: return 8'h01; 14: return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string byte_req(input int i);
        if (i == 0) return "R3";
        if (i <= 9) return "R4";
        if (i == 10) return "R5";
        if (i <= 13) return "R6";
        if (i <= 17) return "R7";
        return "R11";
    endfunction

    function automatic int gsize(input int g);
        return (g == 0 || g == 4 || g == 6) ? 1 : 3;
    endfunction

    function automatic int gap_after(input int g);
        if (g >= 1 && g <= 4) return 5;
        if (g == 6) return 8;
        return 0;
    endfunction

    function automatic bit gated(input int g);
        return !(g == 2 || g == 3 || g == 7);
    endfunction

    function automatic logic [23:0] sample_val(input int k);
        case (k)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            2: return 24'h000001;
            3: return 24'hFFFFFF;
            default: return 24'(k * 32'h0002B3C1) ^ 24'hA55A5A;
        endcase
    endfunction

    int          cyc = 0, dcnt = 0, last_fall = -100000, phase = 0, t_v = 0;
    bit          drdy_run = 1'b1, pend = 1'b0, done_flag = 1'b0, clr_chk = 1'b0;
    logic        prev_sclk = 1'b0;
    logic [7:0]  shreg = '0;
    logic [23:0] pend_val = '0;
    int          bitc = 0, byte_i = 0, grp = 0, byte_in_grp = 0;
    int          rise_in_grp = 0, grp_end = 0, last_rise = 0, nsamp = 0;

    // Converter model and per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            cyc++;
            // data-ready generation
            if (drdy_run) begin
                dcnt = (dcnt == PERIOD - 1) ? 0 : dcnt + 1;
                if (drdy_n && dcnt >= HI) last_fall = cyc;
                drdy_n = (dcnt < HI);
            end else begin
                drdy_n = 1'b1;
                dcnt = 0;
            end
            // R9/R10: strobe and sample, compared every clock
            if (pend) begin
                chk(sample_valid == 1'b1, "R9", "valid strobe", sample_valid, 1);
                chk(sample_data == pend_val, "R9", "sample value", sample_data, pend_val);
                chk(sample_wide == {{8{pend_val[23]}}, pend_val}, "R10", "sign extension",
                    sample_wide, {{8{pend_val[23]}}, pend_val});
                pend = 1'b0;
                nsamp++;
                if (nsamp == 6 && phase == 0) begin
                    phase = 1; t_v = cyc; drdy_run = 1'b0; drdy_n = 1'b1;
                end
                if (nsamp == 8) done_flag = 1'b1;
            end else begin
                chk(sample_valid == 1'b0, "R9", "no strobe expected", sample_valid, 0);
            end
            // R12: timeout flag behaviour
            if (phase == 0) chk(timeout == 1'b0, "R12", "timeout while running", timeout, 0);
            if (phase == 1 && cyc == t_v + TO - 2)
                chk(timeout == 1'b0, "R12", "timeout too early", timeout, 0);
            if (phase == 1 && cyc == t_v + TO + 2)
                chk(timeout == 1'b1, "R12", "timeout raised", timeout, 1);
            if (phase == 1 && cyc == t_v + TO + 20) begin
                phase = 2; drdy_run = 1'b1; dcnt = 0;
            end
            if (phase == 2 && !clr_chk && last_fall > t_v && cyc == last_fall + 6) begin
                chk(timeout == 1'b0, "R12", "timeout cleared by fall", timeout, 0);
                clr_chk = 1'b1;
            end
            // serial clock rising edge: timing checks and miso drive
            if (!prev_sclk && sclk) begin
                if (rise_in_grp == 0) begin
                    if (gated(grp))
                        chk(cyc - last_fall >= 3 && cyc - last_fall <= 2 * HALF + 8,
                            grp >= 8 ? "R11" : "R8", "start after data-ready fall",
                            cyc - last_fall, 4 + HALF);
                    if (grp > 0 && gap_after(grp - 1) > 0) begin
                        chk(cyc - grp_end >= gap_after(grp - 1) * CPU,
                            grp == 7 ? "R7" : (grp == 5 ? "R5" : "R4"), "gap length",
                            cyc - grp_end, gap_after(grp - 1) * CPU);
                        if (!gated(grp))
                            chk(cyc - grp_end <= gap_after(grp - 1) * CPU + 2 * HALF + 8,
                                grp == 7 ? "R7" : "R4", "gap upper bound",
                                cyc - grp_end, gap_after(grp - 1) * CPU);
                    end
                end else if (rise_in_grp % 8 != 0) begin
                    chk(cyc - last_rise == 2 * HALF, "R2", "sclk period",
                        cyc - last_rise, 2 * HALF);
                end
                if (grp >= 7) begin
                    logic [23:0] v;
                    v = sample_val(grp - 7);
                    miso = v[23 - rise_in_grp];
                end else begin
                    miso = 1'b0;
                end
                last_rise = cyc;
                rise_in_grp++;
            end
            // serial clock falling edge: decode mosi byte
            if (prev_sclk && !sclk) begin
                shreg = {shreg[6:0], mosi};
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    chk(shreg == exp_byte(byte_i), byte_req(byte_i), "mosi byte",
                        shreg, exp_byte(byte_i));
                    byte_i++;
                    byte_in_grp++;
                    if (byte_in_grp == gsize(grp)) begin
                        if (grp >= 7) begin
                            pend = 1'b1;
                            pend_val = sample_val(grp - 7);
                        end
                        grp_end = cyc;
                        grp++;
                        byte_in_grp = 0;
                        rise_in_grp = 0;
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    // Reset checks, run control, watchdog and summary.
    initial begin
        repeat (4) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(mosi == 1'b0, "R1", "mosi in reset", mosi, 0);
        chk(sample_valid == 1'b0, "R1", "valid in reset", sample_valid, 0);
        chk(timeout == 1'b0, "R1", "timeout in reset", timeout, 0);
        chk(sample_data == 24'h0, "R1", "data in reset", sample_data, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 150000 && !done_flag; i++) @(negedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 samples actual=%0d expected=8", nsamp);
        end
        chk(clr_chk == 1'b1, "R12", "clear check reached", clr_chk, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule